// File: doc/BRIEF.md
# Search Engine Start-Up Sequencer

This controller takes a lookup engine from reset to a usable state. After the active-low reset is released it sends the engine a one-cycle start request. It waits for the engine to raise its busy flag, and then waits for busy to drop again. At that point it reads the engine's 4-bit completion code. A success code moves the controller to a ready state, where it stays until the next reset. Any other code counts as a failed start, and the controller goes back to idle to run the whole sequence again without outside help.

All decisions are made on the rising clock edge, and the reset is synchronous. The current state is visible on a 2-bit output so that surrounding logic or a debugger can see how far start-up has got. The ready output is the only signal the rest of the chip needs in order to begin sending searches.

Top module: `eng_init_ctrl`

## Requirements
- R1: A clock edge with `rst_n` low puts the controller in IDLE (`state` = 2'd0), with `init_req` = 0 and `ready` = 0, whatever `eng_busy` and `eng_status` are.
- R2: From IDLE, the first clock edge with `rst_n` high moves the controller to INIT_START (`state` = 2'd1). `eng_busy` has no effect while in IDLE.
- R3: `init_req` is high for exactly one cycle: the first cycle spent in INIT_START after each entry. It is low in every other cycle.
- R4: In INIT_START the controller stays put while `eng_busy` = 0. It moves to WAIT_READY (`state` = 2'd2) on the edge where `eng_busy` = 1.
- R5: In WAIT_READY the controller stays put while `eng_busy` = 1, whatever `eng_status` is.
- R6: In WAIT_READY, an edge with `eng_busy` = 0 and `eng_status` = 4'b0001 moves the controller to INIT_DONE (`state` = 2'd3).
- R7: In WAIT_READY, an edge with `eng_busy` = 0 and any `eng_status` other than 4'b0001 returns the controller to IDLE. On the next edge it re-enters INIT_START and issues a new `init_req` pulse.
- R8: `ready` is 1 exactly while the state is INIT_DONE. INIT_DONE holds whatever `eng_busy` and `eng_status` do, until the next reset.
- R9: Reset takes priority over any transition due in the same cycle, including a successful completion in WAIT_READY.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| eng_busy | input | 1 | Busy flag from the engine |
| eng_status | input | 4 | Completion code from the engine, 4'b0001 means success |
| init_req | output | 1 | One-cycle start request to the engine |
| ready | output | 1 | High once start-up has succeeded |
| state | output | 2 | Current state: 0 IDLE, 1 INIT_START, 2 WAIT_READY, 3 INIT_DONE |

## Verification
Two events can fall on the same clock edge: reset being asserted, and the engine releasing busy with a success code while the controller is in WAIT_READY. The bench drives `rst_n` low, `eng_busy` low and `eng_status` = 4'b0001 together on that edge. It expects IDLE with `ready` low, not INIT_DONE. A second collision also gets its own vector: the success code is present while busy is still high, and the code then changes on the same edge where busy falls. The failure path must be taken, which shows that the code is sampled only on the release edge.

// File: rtl/eng_init_pkg.sv
package eng_init_pkg;

    localparam int STATUS_W = 4;
    localparam int STATE_W  = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } eng_init_state_e;

    // Engine handshake inputs sampled together.
    typedef struct packed {
        logic                busy;
        logic [STATUS_W-1:0] code;
    } eng_resp_t;

    // Next state, ignoring reset.
    function automatic eng_init_state_e step_state(
        input eng_init_state_e     cur,
        input eng_resp_t           resp,
        input logic [STATUS_W-1:0] ok_code
    );
        eng_init_state_e nxt;
        nxt = cur;
        unique case (cur)
            ST_IDLE:  nxt = ST_START;
            ST_START: if (resp.busy) nxt = ST_WAIT;
            ST_WAIT:  if (!resp.busy) nxt = (resp.code == ok_code) ? ST_DONE : ST_IDLE;
            ST_DONE:  nxt = ST_DONE;
            default:  nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/eng_init_step.sv
module eng_init_step
    import eng_init_pkg::*;
#(
    parameter int                  SW      = STATUS_W,
    parameter logic [SW-1:0]       OK_CODE = 'd1
) (
    input  eng_init_state_e cur_state,
    input  logic            busy_i,
    input  logic [SW-1:0]   code_i,
    output eng_init_state_e nxt_state,
    output logic            enter_start
);
    eng_resp_t resp;

    always_comb begin
        resp      = '0;
        resp.busy = busy_i;
        resp.code = STATUS_W'(code_i);
        nxt_state = step_state(cur_state, resp, STATUS_W'(OK_CODE));
        enter_start = (nxt_state == ST_START) && (cur_state != ST_START);
    end
endmodule

// File: rtl/eng_init_track.sv
module eng_init_track
    import eng_init_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  eng_init_state_e nxt_state,
    input  logic            enter_start,
    output eng_init_state_e cur_state,
    output logic            pulse_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_state <= ST_IDLE;
            pulse_q   <= 1'b0;
        end else begin
            cur_state <= nxt_state;
            pulse_q   <= enter_start;
        end
    end
endmodule

// File: rtl/eng_init_ctrl.sv
module eng_init_ctrl
    import eng_init_pkg::*;
#(
    parameter int                  SW      = STATUS_W,
    parameter logic [SW-1:0]       OK_CODE = 'd1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eng_busy,
    input  logic [SW-1:0] eng_status,
    output logic          init_req,
    output logic          ready,
    output logic [1:0]    state
);
    eng_init_state_e cur_s;
    eng_init_state_e nxt_s;
    logic            enter_s;

    eng_init_step #(.SW(SW), .OK_CODE(OK_CODE)) u_step (
        .cur_state  (cur_s),
        .busy_i     (eng_busy),
        .code_i     (eng_status),
        .nxt_state  (nxt_s),
        .enter_start(enter_s)
    );

    eng_init_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .nxt_state  (nxt_s),
        .enter_start(enter_s),
        .cur_state  (cur_s),
        .pulse_q    (init_req)
    );

    assign ready = (cur_s == ST_DONE);
    assign state = cur_s;
endmodule

// File: rtl/eng_init_ctrl_chk.sv
module eng_init_ctrl_chk #(
    parameter int            SW      = 4,
    parameter logic [SW-1:0] OK_CODE = 'd1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          eng_busy,
    input logic [SW-1:0] eng_status,
    input logic          init_req,
    input logic          ready,
    input logic [1:0]    state
);
    AST_IDLE_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        state == 2'd0 |=> state == 2'd1); // R2
    AST_PULSE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |-> (state == 2'd1 && $past(state) != 2'd1)); // R3
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |=> !init_req); // R3
    AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd1 && !eng_busy) |=> state == 2'd1); // R4
    AST_START_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd1 && eng_busy) |=> state == 2'd2); // R4
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd2 && eng_busy) |=> state == 2'd2); // R5
    AST_WAIT_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd2 && !eng_busy && eng_status == OK_CODE) |=> state == 2'd3); // R6
    AST_WAIT_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd2 && !eng_busy && eng_status != OK_CODE) |=> state == 2'd0); // R7
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        state == 2'd3 |=> (state == 2'd3 && ready)); // R8
    AST_READY_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(state) == 2'd2); // R8
endmodule

bind eng_init_ctrl eng_init_ctrl_chk #(.SW(SW), .OK_CODE(OK_CODE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eng_busy  (eng_busy),
    .eng_status(eng_status),
    .init_req  (init_req),
    .ready     (ready),
    .state     (state)
);

// File: tb/sim_eng_init_ctrl.sv
module sim_eng_init_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       eng_busy = 1'b0;
    logic [3:0] eng_status = 4'd0;
    logic       init_req;
    logic       ready;
    logic [1:0] state;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    eng_init_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .eng_busy  (eng_busy),
        .eng_status(eng_status),
        .init_req  (init_req),
        .ready     (ready),
        .state     (state)
    );

    // {rst_n, busy, status[3:0], exp_state[1:0], exp_init, exp_ready}
    localparam int NV = 27;
    localparam logic [9:0] VEC [NV] = '{
        {1'b0,1'b1,4'h1, 2'd0,1'b0,1'b0},
        {1'b0,1'b0,4'h0, 2'd0,1'b0,1'b0},
        {1'b1,1'b1,4'h0, 2'd1,1'b1,1'b0},
        {1'b1,1'b0,4'h0, 2'd1,1'b0,1'b0},
        {1'b1,1'b0,4'h1, 2'd1,1'b0,1'b0},
        {1'b1,1'b1,4'h0, 2'd2,1'b0,1'b0},
        {1'b1,1'b1,4'h5, 2'd2,1'b0,1'b0},
        {1'b1,1'b0,4'h2, 2'd0,1'b0,1'b0},
        {1'b1,1'b0,4'h0, 2'd1,1'b1,1'b0},
        {1'b1,1'b1,4'h0, 2'd2,1'b0,1'b0},
        {1'b1,1'b0,4'h0, 2'd0,1'b0,1'b0},
        {1'b1,1'b0,4'h0, 2'd1,1'b1,1'b0},
        {1'b1,1'b1,4'h0, 2'd2,1'b0,1'b0},
        {1'b1,1'b0,4'h1, 2'd3,1'b0,1'b1},
        {1'b1,1'b1,4'h3, 2'd3,1'b0,1'b1},
        {1'b1,1'b0,4'h0, 2'd3,1'b0,1'b1},
        {1'b0,1'b0,4'h1, 2'd0,1'b0,1'b0},
        {1'b1,1'b0,4'h0, 2'd1,1'b1,1'b0},
        {1'b1,1'b1,4'h0, 2'd2,1'b0,1'b0},
        {1'b0,1'b0,4'h1, 2'd0,1'b0,1'b0},
        {1'b1,1'b0,4'h0, 2'd1,1'b1,1'b0},
        {1'b1,1'b1,4'h0, 2'd2,1'b0,1'b0},
        {1'b1,1'b0,4'hF, 2'd0,1'b0,1'b0},
        {1'b1,1'b0,4'h0, 2'd1,1'b1,1'b0},
        {1'b1,1'b1,4'h1, 2'd2,1'b0,1'b0},
        {1'b1,1'b0,4'h8, 2'd0,1'b0,1'b0},
        {1'b1,1'b0,4'h1, 2'd1,1'b1,1'b0}
    };
    string TAG [NV] = '{
        "R1","R1","R2","R3","R4","R4","R5","R7","R7","R4","R7","R7","R4",
        "R6","R8","R8","R1","R2","R4","R9","R3","R4","R7","R7","R5","R7","R7"
    };

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: {state,init_req,ready} actual=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic apply(input logic r, input logic b, input logic [3:0] s);
        rst_n = r; eng_busy = b; eng_status = s;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #1;
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][9], VEC[i][8], VEC[i][7:4]);
            check(TAG[i], {state, init_req, ready}, VEC[i][3:0]);
        end

        // R8: reach INIT_DONE, then hold it through busy/status churn
        apply(1'b1, 1'b1, 4'h0);
        apply(1'b1, 1'b0, 4'h1);
        check("R6", {state, init_req, ready}, {2'd3, 1'b0, 1'b1});
        for (int k = 0; k < 24; k++) begin
            apply(1'b1, k[0], 4'(k * 7));
            check("R8", {state, init_req, ready}, {2'd3, 1'b0, 1'b1});
        end

        // R1: reset while in INIT_START with busy high
        apply(1'b0, 1'b0, 4'h0);
        apply(1'b1, 1'b0, 4'h0);
        check("R3", {state, init_req, ready}, {2'd1, 1'b1, 1'b0});
        apply(1'b0, 1'b1, 4'h1);
        check("R1", {state, init_req, ready}, {2'd0, 1'b0, 1'b0});

        // R3: long stay in INIT_START keeps init_req low after first cycle
        apply(1'b1, 1'b0, 4'h0);
        for (int k = 0; k < 10; k++) begin
            apply(1'b1, 1'b0, 4'h1);
            check("R3", {state, init_req, ready}, {2'd1, 1'b0, 1'b0});
        end
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule